// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between the instruction fetch stage and the execution path of a multithreaded processor core. It keeps one waiting instruction for each warp. Each instruction names a destination register and up to two source registers, and each source has its own use flag. Every cycle the block looks at all occupied slots and finds the warps whose operands have no write in flight. When the execution path is free, it issues one of those warps. The issued instruction leaves its slot, and its destination register is then tracked as in flight in that warp's scoreboard.

A writeback port reports when a result has landed, and that register becomes usable again. A writeback that arrives in the same cycle as the scan counts at once, so a dependent instruction issues on the writeback edge itself. The execution path is shared by all threads of a warp and stays occupied for a fixed number of cycles after each issue. Issue gaps are therefore counted inside the block. An upstream ready signal can also hold issue off entirely. By default the choice among eligible warps rotates after the last issued warp. A parameter swaps this for a fixed lowest-index priority.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `iss_valid` is 0, `slot_busy` is all zeros and every issue field is 0. Every register of every warp starts with no write in flight.
- R2: A fill into a warp whose slot is free sets that warp's `slot_busy` bit on the next cycle. A fill into an occupied slot is dropped, and the stored instruction is kept unchanged. Issuing an instruction frees its slot on the issue edge.
- R3: A warp is eligible only if its destination register has no write in flight and each source whose use flag is 1 has no write in flight. A source whose use flag is 0 is not checked.
- R4: Issuing an instruction marks its destination register as in flight in that warp's scoreboard. A later instruction of the same warp that uses it stalls until a writeback names that warp and register. A writeback naming another warp has no effect on the stall.
- R5: An instruction whose operands are all free issues even while another register of the same warp has a write in flight.
- R6: A writeback presented in the same cycle as an instruction that waits on it lets that instruction issue on that same edge.
- R7: At most one instruction issues per edge. After an issue, the next issue comes no sooner than ISSUE_CYCLES (default 4) edges later.
- R8: No instruction issues on an edge where `exec_ready` is 0.
- R9: With ROUND_ROBIN=1, the scan starts at the warp after the last issued one (warp 0 after reset) and wraps at the top.
- R10: With ROUND_ROBIN=0, the lowest-numbered eligible warp always issues.
- R11: When no warp is eligible, `iss_valid` is 0 for that cycle.
- R12: `iss_valid` is a one-cycle pulse on the cycle after the issue edge. During that pulse, `iss_warp` and the issue fields equal the stored instruction. The earliest issue comes one edge after the fill edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_valid | input | 1 | Fill request for the named warp slot |
| fill_warp | input | WW (3) | Target warp of the fill |
| fill_dst | input | RW (4) | Destination register of the filled instruction |
| fill_src0 | input | RW (4) | First source register |
| fill_src0_en | input | 1 | First source is used |
| fill_src1 | input | RW (4) | Second source register |
| fill_src1_en | input | 1 | Second source is used |
| fill_op | input | OP_W (8) | Opaque operation payload |
| wb_valid | input | 1 | A result has been written back |
| wb_warp | input | WW (3) | Warp of the written-back result |
| wb_reg | input | RW (4) | Register of the written-back result |
| exec_ready | input | 1 | Execution path may accept an issue |
| iss_valid | output | 1 | One-cycle issue pulse |
| iss_warp | output | WW (3) | Issued warp |
| iss_dst | output | RW (4) | Issued destination register |
| iss_src0 | output | RW (4) | Issued first source |
| iss_src0_en | output | 1 | Issued first source use flag |
| iss_src1 | output | RW (4) | Issued second source |
| iss_src1_en | output | 1 | Issued second source use flag |
| iss_op | output | OP_W (8) | Issued operation payload |
| slot_busy | output | NUM_WARPS (8) | Occupied warp slots |

## Verification
The assertions take for granted that `fill_warp` and `wb_warp` stay below NUM_WARPS. They also assume a writeback arrives only for a register that the same warp has in flight, and that the filler looks at `slot_busy` before it fills. The stimulus keeps within these limits. Every writeback it drives names a destination issued earlier, and it drives the unrelated-warp writeback only at a register that is already free. It fills an occupied slot only on purpose, to exercise the dropped-fill rule. It raises `exec_ready` only after the waiting instructions are in place, so the order of issue depends on the arbitration alone.

// File: rtl/warp_issue_sched.sv
`timescale 1ns/1ps
module warp_issue_sched #(
  parameter int NUM_WARPS    = 8,
  parameter int NUM_REGS     = 16,
  parameter int OP_W         = 8,
  parameter int ISSUE_CYCLES = 4,
  parameter bit ROUND_ROBIN  = 1'b1,
  localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_valid,
  input  logic [WW-1:0]        fill_warp,
  input  logic [RW-1:0]        fill_dst,
  input  logic [RW-1:0]        fill_src0,
  input  logic                 fill_src0_en,
  input  logic [RW-1:0]        fill_src1,
  input  logic                 fill_src1_en,
  input  logic [OP_W-1:0]      fill_op,
  input  logic                 wb_valid,
  input  logic [WW-1:0]        wb_warp,
  input  logic [RW-1:0]        wb_reg,
  input  logic                 exec_ready,
  output logic                 iss_valid,
  output logic [WW-1:0]        iss_warp,
  output logic [RW-1:0]        iss_dst,
  output logic [RW-1:0]        iss_src0,
  output logic                 iss_src0_en,
  output logic [RW-1:0]        iss_src1,
  output logic                 iss_src1_en,
  output logic [OP_W-1:0]      iss_op,
  output logic [NUM_WARPS-1:0] slot_busy
);
  localparam int CW = $clog2(ISSUE_CYCLES + 1);
  localparam logic [NUM_REGS-1:0] ONE_HOT0 = NUM_REGS'(1);

  logic [NUM_WARPS-1:0]                slot_v;
  logic [NUM_WARPS-1:0][RW-1:0]        slot_dst, slot_s0, slot_s1;
  logic [NUM_WARPS-1:0]                slot_s0en, slot_s1en;
  logic [NUM_WARPS-1:0][OP_W-1:0]      slot_op;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend_n;
  logic [NUM_WARPS-1:0]                elig;
  logic [CW-1:0]                       busy_cnt;
  logic [WW-1:0]                       rr_ptr;
  logic [WW-1:0]                       pick;
  logic                                hit;
  logic                                fire;
  logic                                fill_ok;

  assign slot_busy = slot_v;
  assign fill_ok   = fill_valid && !slot_v[fill_warp];
  assign fire      = exec_ready && (busy_cnt == '0) && hit;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
    logic [NUM_REGS-1:0] avail;
    assign avail   = pend_n[w] | ((wb_valid && wb_warp == WW'(w)) ? (ONE_HOT0 << wb_reg) : '0);
    assign elig[w] = slot_v[w] & avail[slot_dst[w]]
                   & (~slot_s0en[w] | avail[slot_s0[w]])
                   & (~slot_s1en[w] | avail[slot_s1[w]]);
  end

  if (ROUND_ROBIN) begin : g_rr
    always_comb begin
      pick = '0;
      hit  = 1'b0;
      for (int i = 0; i < NUM_WARPS; i++) begin
        if (!hit && elig[(int'(rr_ptr) + i) % NUM_WARPS]) begin
          pick = WW'((int'(rr_ptr) + i) % NUM_WARPS);
          hit  = 1'b1;
        end
      end
    end
  end else begin : g_fixed
    always_comb begin
      pick = '0;
      hit  = 1'b0;
      for (int i = NUM_WARPS - 1; i >= 0; i--) begin
        if (elig[i]) begin
          pick = WW'(i);
          hit  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v      <= '0;
      slot_dst    <= '0;
      slot_s0     <= '0;
      slot_s1     <= '0;
      slot_s0en   <= '0;
      slot_s1en   <= '0;
      slot_op     <= '0;
      pend_n      <= '1;
      busy_cnt    <= '0;
      rr_ptr      <= '0;
      iss_valid   <= 1'b0;
      iss_warp    <= '0;
      iss_dst     <= '0;
      iss_src0    <= '0;
      iss_src0_en <= 1'b0;
      iss_src1    <= '0;
      iss_src1_en <= 1'b0;
      iss_op      <= '0;
    end else begin
      iss_valid <= fire;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (wb_valid) pend_n[wb_warp][wb_reg] <= 1'b1;
      if (fire) begin
        busy_cnt                     <= CW'(ISSUE_CYCLES - 1);
        rr_ptr                       <= (int'(pick) == NUM_WARPS - 1) ? '0 : pick + 1'b1;
        slot_v[pick]                 <= 1'b0;
        pend_n[pick][slot_dst[pick]] <= 1'b0;
        iss_warp                     <= pick;
        iss_dst                      <= slot_dst[pick];
        iss_src0                     <= slot_s0[pick];
        iss_src0_en                  <= slot_s0en[pick];
        iss_src1                     <= slot_s1[pick];
        iss_src1_en                  <= slot_s1en[pick];
        iss_op                       <= slot_op[pick];
      end
      if (fill_ok) begin
        slot_v[fill_warp]    <= 1'b1;
        slot_dst[fill_warp]  <= fill_dst;
        slot_s0[fill_warp]   <= fill_src0;
        slot_s0en[fill_warp] <= fill_src0_en;
        slot_s1[fill_warp]   <= fill_src1;
        slot_s1en[fill_warp] <= fill_src1_en;
        slot_op[fill_warp]   <= fill_op;
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
`timescale 1ns/1ps
module warp_issue_sched_chk #(
  parameter int NUM_WARPS    = 8,
  parameter int ISSUE_CYCLES = 4,
  localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fill_valid,
  input logic [WW-1:0]        fill_warp,
  input logic                 exec_ready,
  input logic                 iss_valid,
  input logic [WW-1:0]        iss_warp,
  input logic [NUM_WARPS-1:0] slot_busy
);
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '1;
    else if (iss_valid) since <= 16'd1;
    else if (since != '1) since <= since + 16'd1;
  end

  // R7
  issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> since >= 16'(ISSUE_CYCLES));

  // R8
  exec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> $past(exec_ready));

  // R2
  fill_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !slot_busy[fill_warp]) |=> slot_busy[$past(fill_warp)]);

  // R2
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !slot_busy[iss_warp]);

  // R11
  had_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (($past(slot_busy) >> iss_warp) & NUM_WARPS'(1)) != '0);

  // R12
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !iss_valid);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .ISSUE_CYCLES(ISSUE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
  .exec_ready(exec_ready), .iss_valid(iss_valid), .iss_warp(iss_warp),
  .slot_busy(slot_busy)
);

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 1'b0, fill_src0_en = 1'b0, fill_src1_en = 1'b0;
  logic [2:0] fill_warp = '0;
  logic [3:0] fill_dst = '0, fill_src0 = '0, fill_src1 = '0;
  logic [7:0] fill_op = '0;
  logic wb_valid = 1'b0;
  logic [2:0] wb_warp = '0;
  logic [3:0] wb_reg = '0;
  logic exec_ready = 1'b0;

  logic iss_valid, iss_src0_en, iss_src1_en;
  logic [2:0] iss_warp;
  logic [3:0] iss_dst, iss_src0, iss_src1;
  logic [7:0] iss_op, slot_busy;
  logic fp_valid, fp_s0en, fp_s1en;
  logic [2:0] fp_warp;
  logic [3:0] fp_dst, fp_s0, fp_s1;
  logic [7:0] fp_op, fp_busy;

  int ntests = 0;
  int nfail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  warp_issue_sched dut (
    .clk, .rst_n, .fill_valid, .fill_warp, .fill_dst, .fill_src0, .fill_src0_en,
    .fill_src1, .fill_src1_en, .fill_op, .wb_valid, .wb_warp, .wb_reg, .exec_ready,
    .iss_valid, .iss_warp, .iss_dst, .iss_src0, .iss_src0_en, .iss_src1,
    .iss_src1_en, .iss_op, .slot_busy);

  warp_issue_sched #(.ROUND_ROBIN(1'b0)) dut_fp (
    .clk, .rst_n, .fill_valid, .fill_warp, .fill_dst, .fill_src0, .fill_src0_en,
    .fill_src1, .fill_src1_en, .fill_op, .wb_valid, .wb_warp, .wb_reg, .exec_ready,
    .iss_valid(fp_valid), .iss_warp(fp_warp), .iss_dst(fp_dst), .iss_src0(fp_s0),
    .iss_src0_en(fp_s0en), .iss_src1(fp_s1), .iss_src1_en(fp_s1en), .iss_op(fp_op),
    .slot_busy(fp_busy));

  // {dst, src0, src1, src0_en, src1_en, op}
  localparam logic [21:0] TBL [8] = '{
    {4'd1,  4'd2,  4'd3,  1'b1, 1'b1, 8'hA0},
    {4'd4,  4'd0,  4'd0,  1'b0, 1'b0, 8'hA1},
    {4'd7,  4'd7,  4'd0,  1'b1, 1'b0, 8'hA2},
    {4'd15, 4'd14, 4'd13, 1'b1, 1'b1, 8'hA3},
    {4'd0,  4'd1,  4'd1,  1'b1, 1'b1, 8'hA4},
    {4'd9,  4'd0,  4'd8,  1'b0, 1'b1, 8'hA5},
    {4'd12, 4'd3,  4'd5,  1'b1, 1'b1, 8'hA6},
    {4'd2,  4'd6,  4'd6,  1'b0, 1'b0, 8'hA7}
  };

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int w, input int d, input int s0, input bit e0,
                      input int s1, input bit e1, input int op);
    fill_valid = 1'b1; fill_warp = 3'(w); fill_dst = 4'(d);
    fill_src0 = 4'(s0); fill_src0_en = e0; fill_src1 = 4'(s1); fill_src1_en = e1;
    fill_op = 8'(op);
    tick();
    fill_valid = 1'b0;
  endtask

  task automatic wb(input int w, input int r);
    wb_valid = 1'b1; wb_warp = 3'(w); wb_reg = 4'(r);
    tick();
    wb_valid = 1'b0;
  endtask

  task automatic wait_issue(output int c);
    c = 0;
    do begin
      tick();
      c++;
    end while (!iss_valid && c < 30);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    while (cyc < 20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int c;
    idle(3);
    // R1 reset state
    chk("R1 iss_valid", 32'(iss_valid), 0);
    chk("R1 slot_busy", 32'(slot_busy), 0);
    chk("R1 fields", {iss_op, iss_dst, iss_src0, iss_src1, iss_warp}, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", 32'(iss_valid), 0);

    // table walk: R2 fill, R9 rotation, R12 fields, R7 spacing
    for (int w = 0; w < 8; w++)
      fill(w, TBL[w][21:18], TBL[w][17:14], TBL[w][9], TBL[w][13:10], TBL[w][8], TBL[w][7:0]);
    chk("R2 all slots taken", 32'(slot_busy), 32'hFF);
    exec_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wait_issue(c);
      chk("R12 pulse", 32'(iss_valid), 1);
      chk("R9 rotation", 32'(iss_warp), 32'(k));
      chk("R12 fields", {iss_dst, iss_src0, iss_src1, iss_src0_en, iss_src1_en, iss_op}, 32'(TBL[k]));
      chk(k == 0 ? "R12 fill-to-issue" : "R7 spacing", 32'(c), k == 0 ? 32'd1 : 32'd4);
    end
    chk("R2 slots freed", 32'(slot_busy), 0);
    for (int w = 0; w < 8; w++) wb(w, TBL[w][21:18]);
    chk("R11 nothing waiting", 32'(iss_valid), 0);

    // R4 stall and R6 same-cycle writeback
    fill(2, 5, 0, 0, 0, 0, 8'hB0);
    wait_issue(c);
    chk("R4 producer issued", 32'(iss_warp), 2);
    fill(2, 6, 5, 1, 0, 0, 8'hB1);
    idle(8);
    chk("R4 reader stalls", 32'(iss_valid), 0);
    chk("R11 stalled slot held", 32'(slot_busy[2]), 1);
    wb(3, 5);
    chk("R4 other warp wb", 32'(iss_valid), 0);
    wb(2, 5);
    chk("R6 issue on wb edge", 32'(iss_valid), 1);
    chk("R6 op", 32'(iss_op), 32'hB1);
    idle(4);
    wb(2, 6);

    // R3 both sources and destination
    fill(4, 1, 0, 0, 0, 0, 8'hC0);
    wait_issue(c);
    fill(4, 9, 0, 1, 1, 1, 8'hC1);
    idle(6);
    chk("R3 src1 pending", 32'(iss_valid), 0);
    wb(4, 1);
    chk("R3 src1 released", 32'(iss_op), 32'hC1);
    idle(4);
    fill(4, 9, 0, 0, 0, 0, 8'hC2);
    idle(6);
    chk("R3 dst pending", 32'(iss_valid), 0);
    wb(4, 9);
    chk("R3 dst released", {iss_valid, iss_op}, {1'b1, 8'hC2});
    idle(4);

    // R5 independent issue while reg 9 of warp 4 is pending; R3 unused src ignored
    fill(4, 3, 2, 1, 9, 0, 8'hD0);
    wait_issue(c);
    chk("R5 independent issue", {iss_valid, iss_op}, {1'b1, 8'hD0});
    chk("R3 unused src ignored", 32'(c), 1);
    idle(4);
    wb(4, 9);
    wb(4, 3);

    // R8 execution not ready
    exec_ready = 1'b0;
    fill(0, 4, 0, 0, 0, 0, 8'hE0);
    idle(6);
    chk("R8 held off", 32'(iss_valid), 0);
    exec_ready = 1'b1;
    tick();
    chk("R8 released", {iss_valid, iss_op}, {1'b1, 8'hE0});
    wb(0, 4);

    // R2 fill into occupied slot is dropped
    exec_ready = 1'b0;
    fill(5, 2, 0, 0, 0, 0, 8'hF0);
    fill(5, 3, 0, 0, 0, 0, 8'hF1);
    chk("R2 slot occupied", 32'(slot_busy), 32'h20);
    exec_ready = 1'b1;
    wait_issue(c);
    chk("R2 first kept", {iss_dst, iss_op}, {4'd2, 8'hF0});
    idle(6);
    chk("R2 second dropped", {iss_valid, slot_busy}, 0);
    wb(5, 2);

    // R9 rotation from warp 6 versus R10 fixed priority
    exec_ready = 1'b0;
    fill(6, 10, 0, 0, 0, 0, 8'h96);
    fill(1, 10, 0, 0, 0, 0, 8'h91);
    fill(3, 10, 0, 0, 0, 0, 8'h93);
    exec_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_issue(c);
      chk("R9 wrap order", 32'(iss_warp), k == 0 ? 32'd6 : (k == 1 ? 32'd1 : 32'd3));
      chk("R10 fixed order", {fp_valid, fp_warp}, {1'b1, (k == 0 ? 3'd1 : (k == 1 ? 3'd3 : 3'd6))});
    end
    idle(6);
    chk("R11 idle at end", 32'(iss_valid), 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule